// File: doc/BRIEF.md
# Packed Dual-Lane 16-Bit Integer ALU

This execution unit treats each 32-bit operand word as two independent 16-bit lanes and performs the same integer operation on both lanes in parallel. A 7-bit opcode selects among multiply-add, low-half multiply, add, subtract, three shifts, minimum and maximum. Signedness is part of the opcode. A clamp control turns add and subtract into saturating operations.

For each of the three sources, two per-source select bits decide which half of that source word feeds each lane. With these bits the caller can broadcast one half to both lanes or swap the halves without a separate permute step. The shift operations take the value from the second source and the shift amount from the first. The result is captured in a single output register, and a valid flag marks each new result.

Top module: `pk16_alu`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `result` is 0.
- R2: A result is registered at the rising edge where `in_valid` is 1. `out_valid` is 1 for exactly the cycles that follow a valid edge. When `in_valid` is 0, `result` holds its previous value.
- R3: Opcode 0x00 (signed) and opcode 0x09 (unsigned) compute src0*src1+src2 per lane, modulo 2^16.
- R4: Opcode 0x01 returns the low 16 bits of src0*src1 per lane.
- R5: Opcodes 0x02 (signed add), 0x03 (signed subtract), 0x0a (unsigned add) and 0x0b (unsigned subtract) wrap modulo 2^16 when clamp is 0. Subtraction computes src0-src1.
- R6: With clamp set, opcodes 0x0a and 0x0b saturate each lane to the range 0..65535.
- R7: With clamp set, opcodes 0x02 and 0x03 saturate each lane to the range -32768..32767 (0x8000..0x7FFF).
- R8: Opcode 0x04 shifts left, 0x05 shifts right logically and 0x06 shifts right arithmetically. Each shift moves src1 by the amount in the low 4 bits of the same lane of src0.
- R9: Opcodes 0x07 and 0x08 give the signed maximum and minimum of src0 and src1 per lane. Opcodes 0x0c and 0x0d give the unsigned maximum and minimum.
- R10: Bit i of `sel_lo` picks the half of source i that feeds lane 0, and bit i of `sel_hi` does the same for lane 1. In both, 0 selects bits 15:0 and 1 selects bits 31:16. Lane k of the result occupies bits 16k+15:16k.
- R11: Any opcode above 0x0d produces a result of zero.
- R12: Clamp has no effect on opcodes other than the four add and subtract opcodes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| opcode | input | 7 | Operation select |
| src0 | input | 32 | Source 0 (shift amount for shifts) |
| src1 | input | 32 | Source 1 (shifted value for shifts) |
| src2 | input | 32 | Source 2 (addend for multiply-add) |
| sel_lo | input | 3 | Per-source half select for lane 0 |
| sel_hi | input | 3 | Per-source half select for lane 1 |
| clamp | input | 1 | Saturate add and subtract |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 32 | Packed two-lane result |

## Verification
The checker follows the valid flag on every cycle and checks that the result holds across idle cycles. It also checks that unrecognised opcodes give zero, that a saturating unsigned add never falls below its first operand, and that an unsigned maximum is never smaller than either input. Exact arithmetic values are shown only by the bench's scenarios: wrap against saturation at both signed limits, shift amounts with bits set above bit 3, half swapping and broadcast, and clamp applied to opcodes it must not affect.

// File: rtl/pk16_pkg.sv
package pk16_pkg;

    localparam int NUM_LANES = 2;
    localparam int SRC_CNT   = 3;
    localparam int OP_W      = 7;

    typedef enum logic [OP_W-1:0] {
        OP_MAD_S  = 7'h00,
        OP_MUL_LO = 7'h01,
        OP_ADD_S  = 7'h02,
        OP_SUB_S  = 7'h03,
        OP_SHL    = 7'h04,
        OP_SHR_L  = 7'h05,
        OP_SHR_A  = 7'h06,
        OP_MAX_S  = 7'h07,
        OP_MIN_S  = 7'h08,
        OP_MAD_U  = 7'h09,
        OP_ADD_U  = 7'h0a,
        OP_SUB_U  = 7'h0b,
        OP_MAX_U  = 7'h0c,
        OP_MIN_U  = 7'h0d
    } pk_op_e;

endpackage

// File: rtl/pk16_operand_mux.sv
// Routes one half of a source word into each lane.
module pk16_operand_mux #(
    parameter int LANE_W = 16
) (
    input  logic [2*LANE_W-1:0] word,
    input  logic                pick_lo,
    input  logic                pick_hi,
    output logic [LANE_W-1:0]   lane0,
    output logic [LANE_W-1:0]   lane1
);
    logic [LANE_W-1:0] half_bot;
    logic [LANE_W-1:0] half_top;

    assign half_bot = word[LANE_W-1:0];
    assign half_top = word[2*LANE_W-1:LANE_W];

    assign lane0 = pick_lo ? half_top : half_bot;
    assign lane1 = pick_hi ? half_top : half_bot;
endmodule

// File: rtl/pk16_lane_unit.sv
// Integer datapath for a single lane.
module pk16_lane_unit
    import pk16_pkg::*;
#(
    parameter int LANE_W = 16
) (
    input  logic [OP_W-1:0]   op,
    input  logic              clamp,
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    input  logic [LANE_W-1:0] c,
    output logic [LANE_W-1:0] y
);
    localparam int SH_W = $clog2(LANE_W);
    localparam logic [LANE_W-1:0] S_MAX = {1'b0, {(LANE_W-1){1'b1}}};
    localparam logic [LANE_W-1:0] S_MIN = {1'b1, {(LANE_W-1){1'b0}}};
    localparam logic [LANE_W-1:0] U_MAX = {LANE_W{1'b1}};

    logic [LANE_W-1:0] prod_lo;
    logic [LANE_W-1:0] mad_v;
    logic [LANE_W:0]   u_sum;
    logic [LANE_W:0]   u_dif;
    logic [LANE_W:0]   s_sum;
    logic [LANE_W:0]   s_dif;
    logic [LANE_W-1:0] add_u_v, sub_u_v, add_s_v, sub_s_v;
    logic [SH_W-1:0]   shamt;
    logic [LANE_W-1:0] shl_v, shr_l_v, shr_a_v;
    logic              s_gt, u_gt;

    // Multiply family: low half of the product, wraps.
    assign prod_lo = a * b;
    assign mad_v   = prod_lo + c;

    // Extended-width sums expose carry, borrow and signed overflow.
    assign u_sum = {1'b0, a} + {1'b0, b};
    assign u_dif = {1'b0, a} - {1'b0, b};
    assign s_sum = {a[LANE_W-1], a} + {b[LANE_W-1], b};
    assign s_dif = {a[LANE_W-1], a} - {b[LANE_W-1], b};

    always_comb begin
        add_u_v = u_sum[LANE_W-1:0];
        if (clamp && u_sum[LANE_W]) add_u_v = U_MAX;
        sub_u_v = u_dif[LANE_W-1:0];
        if (clamp && u_dif[LANE_W]) sub_u_v = '0;
        add_s_v = s_sum[LANE_W-1:0];
        if (clamp && (s_sum[LANE_W] != s_sum[LANE_W-1]))
            add_s_v = s_sum[LANE_W] ? S_MIN : S_MAX;
        sub_s_v = s_dif[LANE_W-1:0];
        if (clamp && (s_dif[LANE_W] != s_dif[LANE_W-1]))
            sub_s_v = s_dif[LANE_W] ? S_MIN : S_MAX;
    end

    // Reversed-operand shifts: amount from a, value from b.
    assign shamt   = a[SH_W-1:0];
    assign shl_v   = b << shamt;
    assign shr_l_v = b >> shamt;
    assign shr_a_v = $unsigned($signed(b) >>> shamt);

    assign s_gt = $signed(a) > $signed(b);
    assign u_gt = a > b;

    always_comb begin
        unique case (op)
            OP_MAD_S,
            OP_MAD_U:  y = mad_v;
            OP_MUL_LO: y = prod_lo;
            OP_ADD_S:  y = add_s_v;
            OP_SUB_S:  y = sub_s_v;
            OP_ADD_U:  y = add_u_v;
            OP_SUB_U:  y = sub_u_v;
            OP_SHL:    y = shl_v;
            OP_SHR_L:  y = shr_l_v;
            OP_SHR_A:  y = shr_a_v;
            OP_MAX_S:  y = s_gt ? a : b;
            OP_MIN_S:  y = s_gt ? b : a;
            OP_MAX_U:  y = u_gt ? a : b;
            OP_MIN_U:  y = u_gt ? b : a;
            default:   y = '0;
        endcase
    end
endmodule

// File: rtl/pk16_alu.sv
module pk16_alu
    import pk16_pkg::*;
#(
    parameter int LANE_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [OP_W-1:0]               opcode,
    input  logic [NUM_LANES*LANE_W-1:0]   src0,
    input  logic [NUM_LANES*LANE_W-1:0]   src1,
    input  logic [NUM_LANES*LANE_W-1:0]   src2,
    input  logic [SRC_CNT-1:0]            sel_lo,
    input  logic [SRC_CNT-1:0]            sel_hi,
    input  logic                          clamp,
    output logic                          out_valid,
    output logic [NUM_LANES*LANE_W-1:0]   result
);
    localparam int WORD_W = NUM_LANES * LANE_W;

    logic [WORD_W-1:0] src_word [SRC_CNT];
    logic [LANE_W-1:0] opnd     [SRC_CNT][NUM_LANES];
    logic [WORD_W-1:0] lane_res;

    assign src_word[0] = src0;
    assign src_word[1] = src1;
    assign src_word[2] = src2;

    for (genvar s = 0; s < SRC_CNT; s++) begin : g_src
        pk16_operand_mux #(.LANE_W(LANE_W)) u_mux (
            .word    (src_word[s]),
            .pick_lo (sel_lo[s]),
            .pick_hi (sel_hi[s]),
            .lane0   (opnd[s][0]),
            .lane1   (opnd[s][1])
        );
    end

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        pk16_lane_unit #(.LANE_W(LANE_W)) u_lane (
            .op    (opcode),
            .clamp (clamp),
            .a     (opnd[0][l]),
            .b     (opnd[1][l]),
            .c     (opnd[2][l]),
            .y     (lane_res[l*LANE_W +: LANE_W])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= lane_res;
        end
    end
endmodule

// File: rtl/pk16_alu_chk.sv
module pk16_alu_chk #(
    parameter int LANE_W = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [6:0]            opcode,
    input logic [2*LANE_W-1:0]   src0,
    input logic [2*LANE_W-1:0]   src1,
    input logic [2:0]            sel_lo,
    input logic [2:0]            sel_hi,
    input logic                  clamp,
    input logic                  out_valid,
    input logic [2*LANE_W-1:0]   result
);
    logic dflt_sel;
    assign dflt_sel = (sel_lo == 3'b000) && (sel_hi == 3'b111);

    assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    assert_unknown_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode > 7'h0d) |=> (result == '0));

    assert_usat_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 7'h0a && clamp && dflt_sel)
        |=> (result[LANE_W-1:0] >= $past(src0[LANE_W-1:0])));

    assert_umax_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 7'h0c && dflt_sel)
        |=> (result[LANE_W-1:0] >= $past(src0[LANE_W-1:0]))
         && (result[LANE_W-1:0] >= $past(src1[LANE_W-1:0])));
endmodule

bind pk16_alu pk16_alu_chk #(.LANE_W(LANE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .opcode    (opcode),
    .src0      (src0),
    .src1      (src1),
    .sel_lo    (sel_lo),
    .sel_hi    (sel_hi),
    .clamp     (clamp),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/sim_pk16_alu.sv
module sim_pk16_alu;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [6:0]  opcode;
    logic [31:0] src0, src1, src2;
    logic [2:0]  sel_lo, sel_hi;
    logic        clamp;
    logic        out_valid;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pk16_alu u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .src0(src0), .src1(src1), .src2(src2),
        .sel_lo(sel_lo), .sel_hi(sel_hi), .clamp(clamp),
        .out_valid(out_valid), .result(result)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one valid operation at a falling edge, check the next falling edge.
    task automatic run_op(input string tag, input logic [6:0] op, input logic cl,
                          input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                          input logic [2:0] slo, input logic [2:0] shi,
                          input logic [31:0] exp);
        @(negedge clk);
        in_valid = 1'b1; opcode = op; clamp = cl;
        src0 = a; src1 = b; src2 = c; sel_lo = slo; sel_hi = shi;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " valid"}, {31'd0, out_valid}, 32'd1);
        check(tag, result, exp);
    endtask

    task automatic t_reset_R1;
        rst_n = 1'b0; in_valid = 1'b0; opcode = '0; clamp = 1'b0;
        src0 = '0; src1 = '0; src2 = '0; sel_lo = 3'b000; sel_hi = 3'b111;
        repeat (3) @(negedge clk);
        check("R1 out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 result", result, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {31'd0, out_valid}, 32'd0);
    endtask

    task automatic t_mad_R3;
        run_op("R3 signed mad", 7'h00, 1'b0, 32'h0003_FFFE, 32'h0005_0007, 32'h0001_000A,
               3'b000, 3'b111, 32'h0010_FFFC);
        run_op("R3 unsigned mad", 7'h09, 1'b0, 32'h0100_0200, 32'h0100_0080, 32'h0005_0003,
               3'b000, 3'b111, 32'h0005_0003);
    endtask

    task automatic t_mul_R4;
        run_op("R4 mul low", 7'h01, 1'b0, 32'h1234_0101, 32'h0010_0100, 32'h0,
               3'b000, 3'b111, 32'h2340_0100);
    endtask

    task automatic t_wrap_R5;
        run_op("R5 uadd wrap", 7'h0a, 1'b0, 32'hFFFF_0001, 32'h0002_0002, 32'h0,
               3'b000, 3'b111, 32'h0001_0003);
        run_op("R5 ssub wrap", 7'h03, 1'b0, 32'h8000_0005, 32'h0001_0007, 32'h0,
               3'b000, 3'b111, 32'h7FFF_FFFE);
        run_op("R5 sadd wrap", 7'h02, 1'b0, 32'h8000_7FF0, 32'hFFFF_0100, 32'h0,
               3'b000, 3'b111, 32'h7FFF_80F0);
        run_op("R5 usub wrap", 7'h0b, 1'b0, 32'h0003_0010, 32'h0005_0004, 32'h0,
               3'b000, 3'b111, 32'hFFFE_000C);
    endtask

    task automatic t_usat_R6;
        run_op("R6 uadd clamp", 7'h0a, 1'b1, 32'hFFFF_0001, 32'h0002_0002, 32'h0,
               3'b000, 3'b111, 32'hFFFF_0003);
        run_op("R6 usub clamp", 7'h0b, 1'b1, 32'h0003_0010, 32'h0005_0004, 32'h0,
               3'b000, 3'b111, 32'h0000_000C);
    endtask

    task automatic t_ssat_R7;
        run_op("R7 sadd clamp", 7'h02, 1'b1, 32'h8000_7FF0, 32'hFFFF_0100, 32'h0,
               3'b000, 3'b111, 32'h8000_7FFF);
        run_op("R7 ssub clamp", 7'h03, 1'b1, 32'h7FFF_8000, 32'hFFFF_0001, 32'h0,
               3'b000, 3'b111, 32'h7FFF_8000);
    endtask

    task automatic t_shift_R8;
        run_op("R8 shl", 7'h04, 1'b0, 32'h0013_0004, 32'h0001_00F0, 32'h0,
               3'b000, 3'b111, 32'h0008_0F00);
        run_op("R8 lshr", 7'h05, 1'b0, 32'h0001_0004, 32'h8000_F000, 32'h0,
               3'b000, 3'b111, 32'h4000_0F00);
        run_op("R8 ashr", 7'h06, 1'b0, 32'h0001_0004, 32'h8000_F000, 32'h0,
               3'b000, 3'b111, 32'hC000_FF00);
    endtask

    task automatic t_minmax_R9;
        run_op("R9 smax", 7'h07, 1'b0, 32'hFFFF_0005, 32'h0001_0003, 32'h0,
               3'b000, 3'b111, 32'h0001_0005);
        run_op("R9 smin", 7'h08, 1'b0, 32'hFFFF_0005, 32'h0001_0003, 32'h0,
               3'b000, 3'b111, 32'hFFFF_0003);
        run_op("R9 umax", 7'h0c, 1'b0, 32'hFFFF_0005, 32'h0001_0003, 32'h0,
               3'b000, 3'b111, 32'hFFFF_0005);
        run_op("R9 umin", 7'h0d, 1'b0, 32'hFFFF_0005, 32'h0001_0003, 32'h0,
               3'b000, 3'b111, 32'h0001_0003);
    endtask

    task automatic t_select_R10;
        run_op("R10 swap src0", 7'h0a, 1'b0, 32'h0001_0002, 32'h0010_0020, 32'h0,
               3'b001, 3'b110, 32'h0012_0021);
        run_op("R10 swap src1", 7'h0a, 1'b0, 32'h0001_0002, 32'h0010_0020, 32'h0,
               3'b010, 3'b101, 32'h0021_0012);
        run_op("R10 broadcast src2", 7'h00, 1'b0, 32'h0001_0001, 32'h0001_0001, 32'h0007_0009,
               3'b100, 3'b111, 32'h0008_0008);
    endtask

    task automatic t_unknown_R11;
        run_op("R11 op 0x0e", 7'h0e, 1'b0, 32'h1234_5678, 32'h1111_2222, 32'h3333_4444,
               3'b000, 3'b111, 32'h0);
        run_op("R11 op 0x7f", 7'h7f, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
               3'b000, 3'b111, 32'h0);
    endtask

    task automatic t_clamp_inert_R12;
        run_op("R12 mul with clamp", 7'h01, 1'b1, 32'h1234_0101, 32'h0010_0100, 32'h0,
               3'b000, 3'b111, 32'h2340_0100);
        run_op("R12 mad with clamp", 7'h00, 1'b1, 32'h0000_7FFF, 32'h0000_0002, 32'h0,
               3'b000, 3'b111, 32'h0000_FFFE);
        run_op("R12 umax with clamp", 7'h0c, 1'b1, 32'hFFFF_0005, 32'h0001_0003, 32'h0,
               3'b000, 3'b111, 32'hFFFF_0005);
    endtask

    task automatic t_pipeline_R2;
        run_op("R2 first", 7'h0a, 1'b0, 32'h0001_0001, 32'h0001_0001, 32'h0,
               3'b000, 3'b111, 32'h0002_0002);
        // Idle cycles with changing operands: result must hold.
        src0 = 32'hAAAA_5555; src1 = 32'h1234_4321; opcode = 7'h01;
        @(negedge clk);
        check("R2 idle valid", {31'd0, out_valid}, 32'd0);
        check("R2 idle hold", result, 32'h0002_0002);
        @(negedge clk);
        check("R2 idle hold 2", result, 32'h0002_0002);
        // Back-to-back valid operations.
        in_valid = 1'b1; opcode = 7'h0a; clamp = 1'b0;
        src0 = 32'h0003_0004; src1 = 32'h0001_0001;
        @(negedge clk);
        check("R2 b2b first", result, 32'h0004_0005);
        check("R2 b2b valid", {31'd0, out_valid}, 32'd1);
        opcode = 7'h0b;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 b2b second", result, 32'h0002_0003);
        check("R2 b2b valid 2", {31'd0, out_valid}, 32'd1);
        @(negedge clk);
        check("R2 drop valid", {31'd0, out_valid}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset_R1();
        t_mad_R3();
        t_mul_R4();
        t_wrap_R5();
        t_usat_R6();
        t_ssat_R7();
        t_shift_R8();
        t_minmax_R9();
        t_select_R10();
        t_unknown_R11();
        t_clamp_inert_R12();
        t_pipeline_R2();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule